// File: doc/BRIEF.md
# Hysteretic Frequency Lock Detector

This block judges whether the divided clock of a clock-recovery oscillator runs close enough to its target rate to pass control from the frequency-acquisition loop to the phase-tracking loop. It counts edges of the divided oscillator clock over a gate of 2^GATE_LOG2 reference cycles. It compares that count with a target value, then drives an active-high loss-of-lock flag and a loop-select output. The target is computed from two select codes, one for the line rate and one for the reference frequency, so a single reference frequency serves every supported line rate.

Locking and unlocking use two different thresholds. The flag clears when the error is at most 500 ppm of the target. Once clear, it sets again only when the error exceeds 1000 ppm. Between the two thresholds the present state is held. The oscillator count crosses into the reference domain as a Gray-coded value through a two-flop synchronizer. Every count is the difference between two successive snapshots, so the synchronizer latency cancels out. The signed error of the latest window is available on an output.

Top module: `freq_lock_detect`

## Requirements
- R1: While reset is high and on the first cycle after it, `lol` is 1, `loop_sel` is 0 (frequency loop) and `err_cnt` is 0.
- R2: The first gate window after reset, or after a select change, only records a baseline snapshot and leaves `lol` and `err_cnt` unchanged. The earliest `lol` can clear is at the end of the second window.
- R3: With `lol` at 1, the end of a window clears `lol` when |err| <= floor(E*500/10^6), where E is the expected count.
- R4: With `lol` at 0, the end of a window sets `lol` when |err| > floor(E*1000/10^6).
- R5: An error above the acquire limit and at or below the release limit leaves `lol` as it was, whether it was locked or unlocked.
- R6: Once per gate of 2^GATE_LOG2 reference cycles, `err_cnt` is updated to (edges counted in the window) - E, as a signed value: positive means the oscillator is fast.
- R7: Reference select `ref_sel` encodes 00 = 19.44 MHz, 01 = 38.88 MHz, 10 = 77.76 MHz and 11 = 155.52 MHz. E is divided by 1, 2, 4 or 8 accordingly.
- R8: Rate select `rate_sel` encodes 00 = 622.08 MHz (32x the 19.44 MHz base), 01 = 155.52 MHz (8x), 10 = 666.51 MHz and 11 = 166.63 MHz. The last two are the 15/14 wrapper rates. For these, E is the native count times 15/14, rounded to nearest. In full, E = round(M * 2^GATE_LOG2 / 2^ref_sel * (15/14 for wrapper)).
- R9: Any change of `rate_sel` or `ref_sel` sets `lol` to 1, selects the frequency loop and clears `err_cnt` on the next clock. It also restarts the gate window.
- R10: `loop_sel` is 1 (phase loop) exactly when `lol` is 0.
- R11: If the oscillator drifts past the release limit whenever the phase loop is selected, and returns to target whenever the frequency loop is selected, then `lol` keeps toggling from window to window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; clocks the gate timer, the decision logic and all outputs |
| osc_clk | input | 1 | Divided recovered-oscillator clock whose edges are counted |
| rst | input | 1 | Synchronous active-high reset, in the reference domain |
| rate_sel | input | 2 | Line rate code (R8) |
| ref_sel | input | 2 | Reference frequency code (R7) |
| lol | output | 1 | Loss-of-lock flag, active high |
| loop_sel | output | 1 | 1 = phase loop drives the oscillator, 0 = frequency loop |
| err_cnt | output | GATE_LOG2+9 | Signed count error of the last evaluated window |

## Verification
The hardest cases to reach are the hysteresis band in both directions and the repeated toggling. Each needs a known lock history and an oscillator offset of a few hundred ppm held across whole windows. The bench sets the oscillator half-period in femtosecond steps. It changes the offset only in the middle of a window, skips the mixed window that follows and checks the clean one after it. For the toggling case, a behavioural oscillator model watches `loop_sel`. It drifts 1500 ppm slow while the phase loop is selected and returns to nominal when the frequency loop takes over.

// File: rtl/fld_pkg.sv
`timescale 1ns/1fs
package fld_pkg;

  localparam int unsigned PPM_ACQ = 500;
  localparam int unsigned PPM_REL = 1000;

  // idx = {rate_sel, ref_sel}; count of divided-oscillator edges per gate
  function automatic longint unsigned exp_count(input int unsigned idx,
                                                input int unsigned gate_log2);
    longint unsigned base;
    base = (((idx >> 2) & 1) != 0) ? 64'd8 : 64'd32;
    base = (base << gate_log2) >> (idx & 3);
    if (((idx >> 3) & 1) != 0) base = (base * 64'd15 + 64'd7) / 64'd14;
    return base;
  endfunction

  function automatic longint unsigned ppm_of(input longint unsigned cnt,
                                             input int unsigned ppm);
    longint unsigned p;
    p = 64'(ppm);
    return (cnt * p) / 64'd1000000;
  endfunction

endpackage

// File: rtl/fld_osc_count.sv
`timescale 1ns/1fs
module fld_osc_count #(
  parameter int unsigned CNT_W = 24
)(
  input  logic             osc_clk,
  input  logic             rst,
  output logic [CNT_W-1:0] gray_out
);
  logic             rst_meta, rst_sync;
  logic [CNT_W-1:0] bin_q;

  // reset crosses into the oscillator domain through two flops
  always_ff @(posedge osc_clk) begin
    rst_meta <= rst;
    rst_sync <= rst_meta;
  end

  always_ff @(posedge osc_clk) begin
    if (rst_sync) begin
      bin_q    <= '0;
      gray_out <= '0;
    end else begin
      bin_q    <= bin_q + 1'b1;
      gray_out <= bin_q ^ (bin_q >> 1);
    end
  end
endmodule

// File: rtl/fld_gray_sync.sv
`timescale 1ns/1fs
module fld_gray_sync #(
  parameter int unsigned CNT_W = 24
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] gray_in,
  output logic [CNT_W-1:0] bin_out
);
  logic [CNT_W-1:0] s1_q, s2_q, bin_c;

  always_comb begin
    bin_c[CNT_W-1] = s2_q[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) bin_c[i] = bin_c[i+1] ^ s2_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q    <= '0;
      s2_q    <= '0;
      bin_out <= '0;
    end else begin
      s1_q    <= gray_in;
      s2_q    <= s1_q;
      bin_out <= bin_c;
    end
  end
endmodule

// File: rtl/fld_gate.sv
`timescale 1ns/1fs
module fld_gate #(
  parameter int unsigned GATE_LOG2 = 16
)(
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  logic [GATE_LOG2-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= (cnt_q == '1);
    end
  end
endmodule

// File: rtl/fld_decide.sv
`timescale 1ns/1fs
module fld_decide #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned ERR_W = CNT_W + 1
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    restart,
  input  logic                    tick,
  input  logic [CNT_W-1:0]        cnt_now,
  input  logic [CNT_W-1:0]        exp_cnt,
  input  logic [CNT_W-1:0]        thr_acq,
  input  logic [CNT_W-1:0]        thr_rel,
  output logic                    lol,
  output logic                    loop_sel,
  output logic signed [ERR_W-1:0] err_cnt
);
  logic [CNT_W-1:0]        prev_q, diff;
  logic                    primed_q;
  logic signed [ERR_W-1:0] err_n;
  logic [ERR_W-1:0]        mag;
  logic                    in_acq, out_rel;

  always_comb begin
    diff    = cnt_now - prev_q;
    err_n   = $signed({1'b0, diff}) - $signed({1'b0, exp_cnt});
    mag     = err_n[ERR_W-1] ? ERR_W'(-err_n) : ERR_W'(err_n);
    in_acq  = (mag <= {1'b0, thr_acq});
    out_rel = (mag >  {1'b0, thr_rel});
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      lol      <= 1'b1;
      loop_sel <= 1'b0;
      err_cnt  <= '0;
    end else if (tick) begin
      prev_q   <= cnt_now;
      primed_q <= 1'b1;
      if (primed_q) begin
        err_cnt <= err_n;
        if (lol && in_acq) begin
          lol      <= 1'b0;
          loop_sel <= 1'b1;
        end else if (!lol && out_rel) begin
          lol      <= 1'b1;
          loop_sel <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/freq_lock_detect.sv
`timescale 1ns/1fs
module freq_lock_detect #(
  parameter int unsigned GATE_LOG2 = 16,
  parameter int unsigned CNT_W     = GATE_LOG2 + 8,
  parameter int unsigned ERR_W     = CNT_W + 1
)(
  input  logic                    ref_clk,
  input  logic                    osc_clk,
  input  logic                    rst,
  input  logic [1:0]              rate_sel,
  input  logic [1:0]              ref_sel,
  output logic                    lol,
  output logic                    loop_sel,
  output logic signed [ERR_W-1:0] err_cnt
);
  localparam int unsigned IDX_W = 4;
  localparam int unsigned NSEL  = 1 << IDX_W;

  logic [IDX_W-1:0] sel_q;
  logic             restart, tick;
  logic [CNT_W-1:0] gray, cnt_now;
  logic [CNT_W-1:0] exp_q, acq_q, rel_q;
  logic [CNT_W-1:0] exp_tab [NSEL];
  logic [CNT_W-1:0] acq_tab [NSEL];
  logic [CNT_W-1:0] rel_tab [NSEL];

  // expected count and ppm limits for every select combination
  for (genvar i = 0; i < NSEL; i++) begin : g_tab
    localparam longint unsigned E = fld_pkg::exp_count(i, GATE_LOG2);
    assign exp_tab[i] = CNT_W'(E);
    assign acq_tab[i] = CNT_W'(fld_pkg::ppm_of(E, fld_pkg::PPM_ACQ));
    assign rel_tab[i] = CNT_W'(fld_pkg::ppm_of(E, fld_pkg::PPM_REL));
  end

  always_ff @(posedge ref_clk) begin
    sel_q <= {rate_sel, ref_sel};
    exp_q <= exp_tab[sel_q];
    acq_q <= acq_tab[sel_q];
    rel_q <= rel_tab[sel_q];
  end

  assign restart = !rst && ({rate_sel, ref_sel} != sel_q);

  fld_osc_count #(.CNT_W(CNT_W)) u_osc (
    .osc_clk  (osc_clk),
    .rst      (rst),
    .gray_out (gray)
  );

  fld_gray_sync #(.CNT_W(CNT_W)) u_sync (
    .clk     (ref_clk),
    .rst     (rst),
    .gray_in (gray),
    .bin_out (cnt_now)
  );

  fld_gate #(.GATE_LOG2(GATE_LOG2)) u_gate (
    .clk     (ref_clk),
    .rst     (rst),
    .restart (restart),
    .tick    (tick)
  );

  fld_decide #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_dec (
    .clk      (ref_clk),
    .rst      (rst),
    .restart  (restart),
    .tick     (tick),
    .cnt_now  (cnt_now),
    .exp_cnt  (exp_q),
    .thr_acq  (acq_q),
    .thr_rel  (rel_q),
    .lol      (lol),
    .loop_sel (loop_sel),
    .err_cnt  (err_cnt)
  );
endmodule

// File: rtl/fld_checker.sv
`timescale 1ns/1fs
module fld_checker #(
  parameter int unsigned GATE_LOG2 = 16,
  parameter int unsigned CNT_W     = GATE_LOG2 + 8,
  parameter int unsigned ERR_W     = CNT_W + 1
)(
  input logic                    ref_clk,
  input logic                    rst,
  input logic [1:0]              rate_sel,
  input logic [1:0]              ref_sel,
  input logic                    lol,
  input logic                    loop_sel,
  input logic signed [ERR_W-1:0] err_cnt
);
  localparam int unsigned SW  = GATE_LOG2 + 2;
  localparam int unsigned WIN = 1 << GATE_LOG2;

  logic [3:0]       sel_prev;
  logic [SW-1:0]    since;
  logic [ERR_W-1:0] mag, acq_lim, rel_lim;

  always_ff @(posedge ref_clk) sel_prev <= {rate_sel, ref_sel};

  always_ff @(posedge ref_clk) begin
    if (rst || ({rate_sel, ref_sel} != sel_prev)) since <= '0;
    else if (since != '1)                          since <= since + 1'b1;
  end

  always_comb begin
    mag     = err_cnt[ERR_W-1] ? ERR_W'(-err_cnt) : ERR_W'(err_cnt);
    acq_lim = ERR_W'(fld_pkg::ppm_of(fld_pkg::exp_count(32'(sel_prev), GATE_LOG2), fld_pkg::PPM_ACQ));
    rel_lim = ERR_W'(fld_pkg::ppm_of(fld_pkg::exp_count(32'(sel_prev), GATE_LOG2), fld_pkg::PPM_REL));
  end

  assert_no_early_lock_R2: assert property (@(posedge ref_clk) disable iff (rst)
    $fell(lol) |-> (since >= SW'(WIN)));

  assert_acquire_limit_R3: assert property (@(posedge ref_clk) disable iff (rst)
    $fell(lol) |-> (mag <= acq_lim));

  assert_release_limit_R4: assert property (@(posedge ref_clk) disable iff (rst)
    ($rose(lol) && (err_cnt != 0)) |-> (mag > rel_lim));

  assert_select_restart_R9: assert property (@(posedge ref_clk) disable iff (rst)
    ({rate_sel, ref_sel} != $past({rate_sel, ref_sel})) |=> (lol && (err_cnt == 0)));

  assert_loop_follows_R10: assert property (@(posedge ref_clk) disable iff (rst)
    loop_sel != lol);
endmodule

bind freq_lock_detect fld_checker #(.GATE_LOG2(GATE_LOG2), .CNT_W(CNT_W), .ERR_W(ERR_W)) u_fld_chk (
  .ref_clk  (ref_clk),
  .rst      (rst),
  .rate_sel (rate_sel),
  .ref_sel  (ref_sel),
  .lol      (lol),
  .loop_sel (loop_sel),
  .err_cnt  (err_cnt)
);

// File: tb/freq_lock_detect_test.sv
`timescale 1ns/1fs
module freq_lock_detect_test;
  localparam int GL    = 11;
  localparam int W     = 1 << GL;
  localparam int CNT_W = GL + 8;
  localparam int ERR_W = CNT_W + 1;

  typedef struct {
    int    at;
    bit    chk_lol;
    bit    exp_lol;
    bit    chk_err;
    int    lo;
    int    hi;
    string req;
  } item_t;

  logic ref_clk = 1'b0, osc_clk = 1'b0, rst = 1'b1;
  logic [1:0] rate_sel = 2'b01, ref_sel = 2'b00;
  logic lol, loop_sel;
  logic signed [ERR_W-1:0] err_cnt;

  real   osc_ppm  = 0.0;
  bit    drift_on = 1'b0;
  bit    done     = 1'b0;
  int    cyc = 0, total = 0, bad = 0, rises = 0, falls = 0;
  item_t sb[$];
  item_t it;

  freq_lock_detect #(.GATE_LOG2(GL)) uut (
    .ref_clk(ref_clk), .osc_clk(osc_clk), .rst(rst),
    .rate_sel(rate_sel), .ref_sel(ref_sel),
    .lol(lol), .loop_sel(loop_sel), .err_cnt(err_cnt)
  );

  always #4 ref_clk = ~ref_clk;                       // 125 MHz reference
  always begin                                        // ~1 GHz divided oscillator
    #(0.5 * (1.0 + osc_ppm * 1.0e-6));
    osc_clk = ~osc_clk;
  end

  // oscillator model for lost data: phase loop lets it drift, frequency loop pulls back
  always @(loop_sel) if (drift_on) osc_ppm = loop_sel ? 1500.0 : 0.0;
  always @(posedge lol) if (drift_on) rises++;
  always @(negedge lol) if (drift_on) falls++;

  task automatic check_rng(string req, string what, longint act, longint lo, longint hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // monitor: pops expectations at their sample cycle
  always @(negedge ref_clk) begin
    cyc++;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      it = sb.pop_front();
      if (it.chk_lol) begin
        check_rng(it.req, "lol", longint'(lol), longint'(it.exp_lol), longint'(it.exp_lol));
        check_rng({it.req, " R10"}, "loop_sel", longint'(loop_sel),
                  longint'(!it.exp_lol), longint'(!it.exp_lol));
      end
      if (it.chk_err) check_rng(it.req, "err_cnt", longint'(err_cnt), it.lo, it.hi);
    end
  end

  task automatic push(int at, bit cl, bit el, bit ce, int lo, int hi, string req);
    item_t x;
    x.at = at; x.chk_lol = cl; x.exp_lol = el; x.chk_err = ce;
    x.lo = lo; x.hi = hi; x.req = req;
    sb.push_back(x);
  endtask

  task automatic expect_win(int anchor, int w, bit el, bit ce, int lo, int hi, string req);
    push(anchor + w * W + W / 2, 1'b1, el, ce, lo, hi, req);
  endtask

  task automatic wait_to(int n);
    while (cyc < n) @(negedge ref_clk);
    #1;
  endtask

  task automatic sel_case(logic [1:0] r, logic [1:0] f, int e, string req);
    int b;
    rate_sel = r; ref_sel = f;
    b = cyc;
    push(b + 3, 1'b1, 1'b1, 1'b1, 0, 0, "R9");
    expect_win(b, 2, 1'b1, 1'b1, e - 2, e + 2, req);
    wait_to(b + 2 * W + W / 2);
  endtask

  initial begin
    int a, c;
    repeat (10) @(negedge ref_clk);
    #1;
    check_rng("R1", "lol in reset", longint'(lol), 1, 1);
    check_rng("R1", "loop_sel in reset", longint'(loop_sel), 0, 0);
    check_rng("R1", "err_cnt in reset", longint'(err_cnt), 0, 0);
    rst = 1'b0;
    a = cyc;
    push(a + 2, 1'b1, 1'b1, 1'b1, 0, 0, "R1");
    // nominal: E = 8<<11 = 16384, acquire limit 8, release limit 16
    expect_win(a, 1, 1'b1, 1'b1, 0, 0, "R2");
    expect_win(a, 2, 1'b0, 1'b1, -1, 1, "R3 R6");
    wait_to(a + 2 * W + W / 2);
    osc_ppm = 700.0;                                   // about -11.5 counts
    expect_win(a, 4, 1'b0, 1'b1, -13, -10, "R5 locked hold");
    wait_to(a + 4 * W + W / 2);
    osc_ppm = 1500.0;                                  // about -24.6 counts
    expect_win(a, 6, 1'b1, 1'b1, -26, -23, "R4");
    wait_to(a + 6 * W + W / 2);
    osc_ppm = 700.0;
    expect_win(a, 8, 1'b1, 1'b1, -13, -10, "R5 unlocked hold");
    wait_to(a + 8 * W + W / 2);
    osc_ppm = -300.0;                                  // about +4.9 counts
    expect_win(a, 10, 1'b0, 1'b1, 3, 7, "R3 R6 fast");
    wait_to(a + 10 * W + W / 2);
    osc_ppm = 0.0;

    // select codes; actual count stays 16384
    sel_case(2'b00, 2'b00, 16384 - 65536, "R8 rate00");
    sel_case(2'b10, 2'b00, 16384 - 70217, "R8 rate10");
    sel_case(2'b11, 2'b00, 16384 - 17554, "R8 rate11");
    sel_case(2'b01, 2'b01, 16384 - 8192,  "R7 ref01");
    sel_case(2'b01, 2'b10, 16384 - 4096,  "R7 ref10");
    sel_case(2'b01, 2'b11, 16384 - 2048,  "R7 ref11");

    // back to nominal, then loss of data with valid reference
    rate_sel = 2'b01; ref_sel = 2'b00;
    c = cyc;
    expect_win(c, 2, 1'b0, 1'b1, -1, 1, "R9 relock");
    wait_to(c + 2 * W + W / 2);
    drift_on = 1'b1;
    osc_ppm  = 1500.0;
    wait_to(c + 14 * W + W / 2);
    check_rng("R11", "lol rises", longint'(rises), 3, 100);
    check_rng("R11", "lol falls", longint'(falls), 3, 100);
    check_rng("R11", "pending items", longint'(sb.size()), 0, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule